// File: doc/BRIEF.md
# Complementary Third-Order Two-Way Audio Band Splitter

This block divides one stream of signed PCM samples into a low band and a high band for a two-way active loudspeaker. The low band comes from a third-order recursive filter whose analog prototype is (3Ts+1)/(Ts+1)^3. That prototype has three coincident real poles and rolls off at twelve decibels per octave, with a modest overshoot. The high band is not filtered on its own. It is the input minus the low band, computed at full internal precision, so the two bands add back to the input exactly. The summed acoustic path therefore keeps the phase of the input.

A small state machine runs the whole filter with one multiplier. In ST_IDLE it accepts a sample when in_valid is high. ST_MAC then spends seven cycles on the four feed-forward taps and the three feedback taps. ST_SETTLE scales and clamps the accumulator and forms both wide bands. ST_QUANT requantizes both bands to the output width and registers them. ST_EMIT holds the result until out_ready is high, then returns to ST_IDLE. The filter coefficients are parameters that are computed offline with the bilinear transform. By default they place the three poles at z = 0.75.

Each band is requantized once, on the way to the 24-bit output. By default, triangular dither from two free-running 32-bit shift-register generators is added at that point. Setting a parameter builds an undithered variant that rounds to nearest instead. The wide low band and the wide high band, taken before requantization, are also available as output ports.

Top module: `xover3_split`

## Requirements
- R1: After a synchronous reset, in_ready is 1, out_valid is 0 and all filter history is zero, so the first sample is filtered from a clean state.
- R2: in_ready is 1 only while the block is idle and out_valid is low. A sample is taken on a clock edge where in_valid and in_ready are both 1.
- R3: out_valid rises exactly 9 clock cycles after the edge that accepted the sample.
- R4: While out_valid is 1 and out_ready is 0, out_valid stays 1 and out_lo, out_hi, lo_wide and hi_wide do not change. After the edge where out_ready is seen high, out_valid is 0.
- R5: The wide input is w = in_sample * 2^16, held in 42 bits. lo_wide is y[n] = floor((b0 w[n] + b1 w[n-1] + b2 w[n-2] + b3 w[n-3] - a1 y[n-1] - a2 y[n-2] - a3 y[n-3]) / 2^20), clamped to the signed 42-bit range. The coefficients are 24-bit signed numbers with 20 fraction bits. Their defaults are b = 45056, 49152, -36864, -40960 and a = -2359296, 1769472, -442368.
- R6: lo_wide + hi_wide equals in_sample * 2^16 exactly, for every sample.
- R7: In the undithered variant, each output is clamp(floor((v + 2^15) / 2^16)) of its wide band v, where clamp limits to the signed 24-bit range.
- R8: In the dithered variant, each output differs from the undithered value of R7 by at most one LSB.
- R9: Dither for each band is u1 - u2, where u1 and u2 are 16-bit slices of two 32-bit maximal-length shift registers. The registers reset to nonzero seeds and are never zero. Over a long low-level signal, the dithered output differs from the rounded output at least once.
- R10: A wide band beyond the output range saturates to 8388607 or to -8388608 and never wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input sample is present |
| in_ready | output | 1 | Block can accept a sample |
| in_sample | input | 24 | Signed input sample |
| out_valid | output | 1 | Band outputs are valid |
| out_ready | input | 1 | Consumer takes the band outputs |
| out_lo | output | 24 | Requantized low band |
| out_hi | output | 24 | Requantized high band |
| lo_wide | output | 42 | Low band at internal precision |
| hi_wide | output | 43 | High band at internal precision |

## Verification
The bench runs a unit impulse, several large and small steps, a sweep over every small input value from -64 to 63, and a pseudo-random stretch. It compares each wide band against a bit-exact model and checks that the two bands sum exactly to the input. A wrong tap order, a coefficient with the wrong sign, or a truncation in the wrong place would make the low band drift from the model within a few samples. Full-scale steps with opposite signs drive the 25 % overshoot past the output range, so an output stage that wraps instead of saturating would flip sign at the peak. The low-level sweep compares the dithered instance with the undithered one. Dither larger than one LSB would break the tolerance, and a generator stuck at zero would never make the two instances differ.

// File: rtl/xover_pkg.sv
`timescale 1ns/1ps
package xover_pkg;

    localparam int LFSR_W = 32;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_MAC,
        ST_SETTLE,
        ST_QUANT,
        ST_EMIT
    } xo_state_e;

endpackage

// File: rtl/xover_lfsr.sv
`timescale 1ns/1ps
module xover_lfsr
    import xover_pkg::*;
#(
    parameter logic [LFSR_W-1:0] SEED = 32'h1
) (
    input  logic              clk,
    input  logic              rst,
    output logic [LFSR_W-1:0] state
);

    logic fb_bit;

    // polynomial x^32 + x^22 + x^2 + x + 1 (maximal length)
    assign fb_bit = state[31] ^ state[21] ^ state[1] ^ state[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SEED;
        end else begin
            state <= {state[LFSR_W-2:0], fb_bit};
        end
    end

endmodule

// File: rtl/xover_requant.sv
`timescale 1ns/1ps
module xover_requant #(
    parameter int WI     = 43,
    parameter int GB     = 16,
    parameter int DW     = 24,
    parameter bit DITHER = 1'b1
) (
    input  logic signed [WI-1:0] wide_in,
    input  logic        [GB-1:0] rnd_a,
    input  logic        [GB-1:0] rnd_b,
    output logic signed [DW-1:0] narrow_out
);

    localparam int SW = WI + 2;
    localparam logic signed [SW-1:0] HALF  = {{(SW-GB){1'b0}}, 1'b1, {(GB-1){1'b0}}};
    localparam logic signed [SW-1:0] Q_MAX = {{(SW-DW+1){1'b0}}, {(DW-1){1'b1}}};
    localparam logic signed [SW-1:0] Q_MIN = {{(SW-DW+1){1'b1}}, {(DW-1){1'b0}}};

    logic signed [GB:0]   dith;
    logic signed [SW-1:0] summed;
    logic signed [SW-1:0] scaled;

    generate
        if (DITHER) begin : g_tpdf
            // difference of two uniform values: triangular, spans one output LSB each side
            assign dith = $signed({1'b0, rnd_a}) - $signed({1'b0, rnd_b});
        end else begin : g_round
            assign dith = '0;
        end
    endgenerate

    always_comb begin
        summed = {{2{wide_in[WI-1]}}, wide_in}
               + {{(SW-GB-1){dith[GB]}}, dith}
               + HALF;
        scaled = summed >>> GB;
        if (scaled > Q_MAX) begin
            narrow_out = Q_MAX[DW-1:0];
        end else if (scaled < Q_MIN) begin
            narrow_out = Q_MIN[DW-1:0];
        end else begin
            narrow_out = scaled[DW-1:0];
        end
    end

endmodule

// File: rtl/xover_iir3.sv
`timescale 1ns/1ps
module xover_iir3
    import xover_pkg::*;
#(
    parameter int DW = 24,
    parameter int GB = 16,
    parameter int HR = 2,
    parameter int CW = 24,
    parameter int CF = 20,
    parameter logic signed [CW-1:0] B0 = 24'sd45056,
    parameter logic signed [CW-1:0] B1 = 24'sd49152,
    parameter logic signed [CW-1:0] B2 = -24'sd36864,
    parameter logic signed [CW-1:0] B3 = -24'sd40960,
    parameter logic signed [CW-1:0] A1 = -24'sd2359296,
    parameter logic signed [CW-1:0] A2 = 24'sd1769472,
    parameter logic signed [CW-1:0] A3 = -24'sd442368
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     in_valid,
    input  logic signed [DW-1:0]     in_sample,
    output logic                     in_ready,
    input  logic                     out_ready,
    output logic                     out_valid,
    output logic                     quant_en,
    output logic signed [DW+GB+HR-1:0] lo_wide,
    output logic signed [DW+GB+HR:0]   hi_wide
);

    localparam int IW = DW + GB + HR;
    localparam int AW = IW + CW + 3;
    localparam int NT = 7;
    localparam int TW = $clog2(NT);
    localparam logic signed [AW-1:0] Y_MAX = {{(AW-IW+1){1'b0}}, {(IW-1){1'b1}}};
    localparam logic signed [AW-1:0] Y_MIN = {{(AW-IW+1){1'b1}}, {(IW-1){1'b0}}};

    xo_state_e state_q, state_d;

    logic [TW-1:0]          tap_q;
    logic signed [AW-1:0]   acc_q;
    logic signed [IW-1:0]   x_hist [4];
    logic signed [IW-1:0]   y_hist [3];
    logic signed [IW-1:0]   x_ext;
    logic signed [CW-1:0]   coef;
    logic signed [IW-1:0]   opnd;
    logic                   fbk;
    logic signed [AW-1:0]   prod;
    logic signed [AW-1:0]   shr;
    logic signed [IW-1:0]   y_new;

    assign x_ext = {{HR{in_sample[DW-1]}}, in_sample, {GB{1'b0}}};

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (in_valid) state_d = ST_MAC;
            ST_MAC:    if (tap_q == TW'(NT-1)) state_d = ST_SETTLE;
            ST_SETTLE: state_d = ST_QUANT;
            ST_QUANT:  state_d = ST_EMIT;
            ST_EMIT:   if (out_ready) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state-decoded outputs
    always_comb begin
        in_ready  = 1'b0;
        out_valid = 1'b0;
        quant_en  = 1'b0;
        unique case (state_q)
            ST_IDLE:  in_ready  = 1'b1;
            ST_QUANT: quant_en  = 1'b1;
            ST_EMIT:  out_valid = 1'b1;
            default:  ;
        endcase
    end

    // tap selection: feed-forward taps first, then feedback taps
    always_comb begin
        fbk = 1'b0;
        unique case (tap_q)
            3'd0: begin coef = B0; opnd = x_hist[0]; end
            3'd1: begin coef = B1; opnd = x_hist[1]; end
            3'd2: begin coef = B2; opnd = x_hist[2]; end
            3'd3: begin coef = B3; opnd = x_hist[3]; end
            3'd4: begin coef = A1; opnd = y_hist[0]; fbk = 1'b1; end
            3'd5: begin coef = A2; opnd = y_hist[1]; fbk = 1'b1; end
            3'd6: begin coef = A3; opnd = y_hist[2]; fbk = 1'b1; end
            default: begin coef = '0; opnd = '0; end
        endcase
    end

    assign prod = {{(AW-CW){coef[CW-1]}}, coef} * {{(AW-IW){opnd[IW-1]}}, opnd};

    // scale back to internal format and clamp
    always_comb begin
        shr = acc_q >>> CF;
        if (shr > Y_MAX) begin
            y_new = Y_MAX[IW-1:0];
        end else if (shr < Y_MIN) begin
            y_new = Y_MIN[IW-1:0];
        end else begin
            y_new = shr[IW-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tap_q   <= '0;
            acc_q   <= '0;
            lo_wide <= '0;
            hi_wide <= '0;
            for (int i = 0; i < 4; i++) x_hist[i] <= '0;
            for (int i = 0; i < 3; i++) y_hist[i] <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (in_valid) begin
                        x_hist[0] <= x_ext;
                        acc_q     <= '0;
                        tap_q     <= '0;
                    end
                end
                ST_MAC: begin
                    acc_q <= fbk ? (acc_q - prod) : (acc_q + prod);
                    tap_q <= tap_q + 1'b1;
                end
                ST_SETTLE: begin
                    lo_wide <= y_new;
                    hi_wide <= {x_hist[0][IW-1], x_hist[0]} - {y_new[IW-1], y_new};
                    for (int i = 3; i > 0; i--) x_hist[i] <= x_hist[i-1];
                    y_hist[2] <= y_hist[1];
                    y_hist[1] <= y_hist[0];
                    y_hist[0] <= y_new;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/xover3_split.sv
`timescale 1ns/1ps
module xover3_split
    import xover_pkg::*;
#(
    parameter int DW     = 24,
    parameter int GB     = 16,
    parameter int HR     = 2,
    parameter int CW     = 24,
    parameter int CF     = 20,
    parameter bit DITHER = 1'b1,
    parameter logic signed [CW-1:0] B0 = 24'sd45056,
    parameter logic signed [CW-1:0] B1 = 24'sd49152,
    parameter logic signed [CW-1:0] B2 = -24'sd36864,
    parameter logic signed [CW-1:0] B3 = -24'sd40960,
    parameter logic signed [CW-1:0] A1 = -24'sd2359296,
    parameter logic signed [CW-1:0] A2 = 24'sd1769472,
    parameter logic signed [CW-1:0] A3 = -24'sd442368,
    parameter logic [LFSR_W-1:0] SEED_A = 32'h9E3779B9,
    parameter logic [LFSR_W-1:0] SEED_B = 32'h2545F491
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        in_valid,
    output logic                        in_ready,
    input  logic signed [DW-1:0]        in_sample,
    output logic                        out_valid,
    input  logic                        out_ready,
    output logic signed [DW-1:0]        out_lo,
    output logic signed [DW-1:0]        out_hi,
    output logic signed [DW+GB+HR-1:0]  lo_wide,
    output logic signed [DW+GB+HR:0]    hi_wide
);

    localparam int IW = DW + GB + HR;
    localparam int NB = 2;

    logic                 quant_en;
    logic [LFSR_W-1:0]    lfsr_a_st;
    logic [LFSR_W-1:0]    lfsr_b_st;
    logic signed [IW:0]   band_w [NB];
    logic signed [DW-1:0] band_q [NB];

    xover_iir3 #(
        .DW(DW), .GB(GB), .HR(HR), .CW(CW), .CF(CF),
        .B0(B0), .B1(B1), .B2(B2), .B3(B3),
        .A1(A1), .A2(A2), .A3(A3)
    ) u_core (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_sample (in_sample),
        .in_ready  (in_ready),
        .out_ready (out_ready),
        .out_valid (out_valid),
        .quant_en  (quant_en),
        .lo_wide   (lo_wide),
        .hi_wide   (hi_wide)
    );

    generate
        if (DITHER) begin : g_noise
            xover_lfsr #(.SEED(SEED_A)) u_lfsr_a (.clk(clk), .rst(rst), .state(lfsr_a_st));
            xover_lfsr #(.SEED(SEED_B)) u_lfsr_b (.clk(clk), .rst(rst), .state(lfsr_b_st));
        end else begin : g_quiet
            assign lfsr_a_st = SEED_A;
            assign lfsr_b_st = SEED_B;
        end
    endgenerate

    assign band_w[0] = {lo_wide[IW-1], lo_wide};
    assign band_w[1] = hi_wide;

    for (genvar g = 0; g < NB; g++) begin : g_band
        xover_requant #(
            .WI(IW+1), .GB(GB), .DW(DW), .DITHER(DITHER)
        ) u_rq (
            .wide_in    (band_w[g]),
            .rnd_a      (lfsr_a_st[g*GB +: GB]),
            .rnd_b      (lfsr_b_st[g*GB +: GB]),
            .narrow_out (band_q[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_lo <= '0;
            out_hi <= '0;
        end else if (quant_en) begin
            out_lo <= band_q[0];
            out_hi <= band_q[1];
        end
    end

endmodule

// File: rtl/xover3_split_chk.sv
`timescale 1ns/1ps
module xover3_split_chk #(
    parameter int DW = 24,
    parameter int GB = 16,
    parameter int HR = 2
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       in_valid,
    input logic                       in_ready,
    input logic signed [DW-1:0]       in_sample,
    input logic                       out_valid,
    input logic                       out_ready,
    input logic signed [DW-1:0]       out_lo,
    input logic signed [DW-1:0]       out_hi,
    input logic signed [DW+GB+HR-1:0] lo_wide,
    input logic signed [DW+GB+HR:0]   hi_wide,
    input logic [31:0]                lfsr_a,
    input logic [31:0]                lfsr_b
);

    localparam int IW  = DW + GB + HR;
    localparam int LAT = 9;

    logic signed [DW-1:0] x_cap;
    logic [7:0]           lat_cnt;
    logic signed [IW:0]   band_sum;
    logic signed [IW:0]   x_wide;

    always_ff @(posedge clk) begin
        if (rst) begin
            x_cap   <= '0;
            lat_cnt <= '0;
        end else if (in_valid && in_ready) begin
            x_cap   <= in_sample;
            lat_cnt <= '0;
        end else if (!out_valid && lat_cnt != 8'hFF) begin
            lat_cnt <= lat_cnt + 1'b1;
        end
    end

    assign band_sum = {lo_wide[IW-1], lo_wide} + hi_wide;
    assign x_wide   = {{(HR+1){x_cap[DW-1]}}, x_cap, {GB{1'b0}}};

    AST_READY_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(in_ready && out_valid)); // R2

    AST_FIXED_LAT: assert property (@(posedge clk) disable iff (rst)
        $rose(out_valid) |-> (lat_cnt == 8'(LAT))); // R3

    AST_HOLD: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_lo) && $stable(out_hi) && $stable(lo_wide))); // R4

    AST_DROP: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready) |=> !out_valid); // R4

    AST_COMPLEMENT: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (band_sum == x_wide)); // R6

    AST_LFSR_LIVE: assert property (@(posedge clk) disable iff (rst)
        (lfsr_a != 32'd0) && (lfsr_b != 32'd0)); // R9

endmodule

bind xover3_split xover3_split_chk #(.DW(DW), .GB(GB), .HR(HR)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_sample (in_sample),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_lo    (out_lo),
    .out_hi    (out_hi),
    .lo_wide   (lo_wide),
    .hi_wide   (hi_wide),
    .lfsr_a    (lfsr_a_st),
    .lfsr_b    (lfsr_b_st)
);

// File: tb/test_xover3_split.sv
`timescale 1ns/1ps
module test_xover3_split;

    localparam int DW = 24;
    localparam int GB = 16;
    localparam int HR = 2;
    localparam int IW = DW + GB + HR;
    localparam logic signed [23:0] CB0 = 24'sd45056;
    localparam logic signed [23:0] CB1 = 24'sd49152;
    localparam logic signed [23:0] CB2 = -24'sd36864;
    localparam logic signed [23:0] CB3 = -24'sd40960;
    localparam logic signed [23:0] CA1 = -24'sd2359296;
    localparam logic signed [23:0] CA2 = 24'sd1769472;
    localparam logic signed [23:0] CA3 = -24'sd442368;
    localparam longint OMAX = 8388607;
    localparam longint OMIN = -8388608;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic out_ready = 1'b0;
    logic signed [DW-1:0] in_sample = '0;

    logic in_ready, out_valid, in_ready_p, out_valid_p;
    logic signed [DW-1:0] out_lo, out_hi, out_lo_p, out_hi_p;
    logic signed [IW-1:0] lo_wide, lo_wide_p;
    logic signed [IW:0]   hi_wide, hi_wide_p;

    int checks = 0;
    int errors = 0;
    int diff_cnt = 0;
    bit done = 1'b0;
    longint peak_hi_out = 0;
    longint peak_lo_out = 0;

    // bit-exact model state
    logic signed [IW-1:0] mx [4];
    logic signed [IW-1:0] my [3];

    always #5 clk = ~clk;

    xover3_split #(.DITHER(1'b1)) i_xover3_split (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_sample(in_sample), .out_valid(out_valid), .out_ready(out_ready),
        .out_lo(out_lo), .out_hi(out_hi), .lo_wide(lo_wide), .hi_wide(hi_wide)
    );

    xover3_split #(.DITHER(1'b0)) i_xover3_split_plain (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready_p),
        .in_sample(in_sample), .out_valid(out_valid_p), .out_ready(out_ready),
        .out_lo(out_lo_p), .out_hi(out_hi_p), .lo_wide(lo_wide_p), .hi_wide(hi_wide_p)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic longint round_out(input longint v);
        longint t;
        t = (v + 64'sd32768) >>> 16;
        if (t > OMAX) t = OMAX;
        if (t < OMIN) t = OMIN;
        return t;
    endfunction

    function automatic longint absdiff(input longint a, input longint b);
        return (a > b) ? a - b : b - a;
    endfunction

    task automatic run_sample(input logic signed [DW-1:0] x, input bit hold);
        logic signed [71:0]   acc;
        logic signed [71:0]   shr;
        logic signed [IW-1:0] y;
        longint wx, exp_lo, exp_hi, cap_lo, cap_hi;
        int n;
        // model (R5)
        wx = longint'(x) * 65536;
        mx[3] = mx[2]; mx[2] = mx[1]; mx[1] = mx[0]; mx[0] = IW'(wx);
        acc = CB0 * mx[0] + CB1 * mx[1] + CB2 * mx[2] + CB3 * mx[3]
            - CA1 * my[0] - CA2 * my[1] - CA3 * my[2];
        shr = acc >>> 20;
        if (shr > 72'sh1FFFFFFFFFF) y = {1'b0, {(IW-1){1'b1}}};
        else if (shr < -72'sh20000000000) y = {1'b1, {(IW-1){1'b0}}};
        else y = shr[IW-1:0];
        my[2] = my[1]; my[1] = my[0]; my[0] = y;
        exp_lo = longint'(y);
        exp_hi = wx - exp_lo;

        @(negedge clk);
        in_sample = x;
        in_valid  = 1'b1;
        chk(in_ready == 1'b1, "R2 ready when idle", longint'(in_ready), 1);
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        n = 0;
        while (!out_valid && n < 60) begin
            if (n == 2) chk(in_ready == 1'b0, "R2 not ready while busy", longint'(in_ready), 0);
            @(negedge clk);
            n++;
        end
        chk(n == 9, "R3 latency", n, 9);
        chk(longint'(lo_wide) + longint'(hi_wide) == wx, "R6 band sum",
            longint'(lo_wide) + longint'(hi_wide), wx);
        chk(longint'(lo_wide) == exp_lo, "R5 low band recursion", longint'(lo_wide), exp_lo);
        chk(longint'(out_lo_p) == round_out(exp_lo), "R7 plain low out", longint'(out_lo_p), round_out(exp_lo));
        chk(longint'(out_hi_p) == round_out(exp_hi), "R7 plain high out", longint'(out_hi_p), round_out(exp_hi));
        chk(absdiff(longint'(out_lo), round_out(exp_lo)) <= 1, "R8 dithered low within 1 LSB",
            longint'(out_lo), round_out(exp_lo));
        chk(absdiff(longint'(out_hi), round_out(exp_hi)) <= 1, "R8 dithered high within 1 LSB",
            longint'(out_hi), round_out(exp_hi));
        if (out_lo != out_lo_p || out_hi != out_hi_p) diff_cnt++;
        if (longint'(out_lo_p) > peak_hi_out) peak_hi_out = longint'(out_lo_p);
        if (longint'(out_lo_p) < peak_lo_out) peak_lo_out = longint'(out_lo_p);
        if (hold) begin
            cap_lo = longint'(out_lo);
            cap_hi = longint'(out_hi);
            repeat (2) @(negedge clk);
            chk(out_valid == 1'b1, "R4 valid held", longint'(out_valid), 1);
            chk(longint'(out_lo) == cap_lo && longint'(out_hi) == cap_hi, "R4 data held",
                longint'(out_lo), cap_lo);
        end
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
        chk(out_valid == 1'b0, "R4 valid drops after take", longint'(out_valid), 0);
    endtask

    initial begin
        #1ms;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int idx;
        logic [31:0] lcg;
        for (int i = 0; i < 4; i++) mx[i] = '0;
        for (int i = 0; i < 3; i++) my[i] = '0;
        idx = 0;
        lcg = 32'h1234_5678;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk(in_ready == 1'b1, "R1 in_ready after reset", longint'(in_ready), 1);
        chk(out_valid == 1'b0, "R1 out_valid after reset", longint'(out_valid), 0);

        // impulse from clean state (R1, R5)
        run_sample(24'sd1048576, 1'b1);
        for (int i = 0; i < 40; i++) begin
            run_sample(24'sd0, (i % 7) == 3);
        end
        // mid-level step
        for (int i = 0; i < 50; i++) begin
            run_sample(24'sd3000000, (i % 11) == 0);
        end
        // full-scale steps with overshoot beyond range (R10)
        peak_hi_out = 0;
        peak_lo_out = 0;
        for (int i = 0; i < 40; i++) run_sample(24'sd8388607, 1'b0);
        for (int i = 0; i < 40; i++) run_sample(-24'sd8388608, 1'b0);
        chk(peak_hi_out == OMAX, "R10 positive clip", peak_hi_out, OMAX);
        chk(peak_lo_out == OMIN, "R10 negative clip", peak_lo_out, OMIN);
        for (int i = 0; i < 40; i++) run_sample(24'sd0, 1'b0);
        // low-level sweep over every small value
        diff_cnt = 0;
        for (int v = -64; v < 64; v++) begin
            run_sample(DW'(v), (idx % 13) == 5);
            idx++;
        end
        chk(diff_cnt > 0, "R9 dither active", diff_cnt, 1);
        // pseudo-random stretch
        for (int i = 0; i < 100; i++) begin
            lcg = lcg * 32'd1103515245 + 32'd12345;
            run_sample($signed(lcg[30:7]), (i % 9) == 4);
        end
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule